// File: doc/BRIEF.md
# Fractional Clock Synthesizer Divider

This block derives a slower clock from its input clock. The output frequency is the input frequency divided by twice an unsigned fixed-point division factor. The factor has 3 integer bits and 14 fractional bits, and it sits in the low 17 bits of a 32-bit control register. The stored value is the real divisor multiplied by 2^14.

Each input cycle, an accumulator adds one unit (2^14). When the running sum reaches the active factor, the block subtracts the factor and toggles the output. Fractional factors therefore give half-periods that alternate between two whole-cycle lengths, and the average matches the programmed value. A factor of zero stops the output. A nonzero factor below 1.0 makes the output toggle on every input cycle. The `rise_pulse` output is a one-cycle strobe that can serve as a clock enable in the input domain.

Software can write the whole register or only the factor field, and it can read the register back. A changed factor is adopted at the next toggle event, and the accumulator is cleared at that moment.

Top module: `frac_clk_synth`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `clk_out` and `rise_pulse` are 0 and `rd_data` is 0.
- R2: A cycle with `ctl_we` high loads all 32 bits of `wr_data` into the control register, and `rd_data` shows the new value from the next cycle on.
- R3: A cycle with only `fac_we` high replaces bits 16..0 of the register with `wr_data[16:0]` and leaves bits 31..17 unchanged. When `ctl_we` and `fac_we` are both high, the full write of `ctl_we` wins.
- R4: With a factor of N·2^14 (N = 1..7) active, every half-period of `clk_out` lasts exactly N input cycles.
- R5: With any factor d ≥ 2^14 active, the number of `clk_out` rising edges in a window of W input cycles is within one of W·2^14/(2·d).
- R6: With a nonzero factor below 2^14 active, `clk_out` inverts on every input cycle.
- R7: With a factor of zero active, `clk_out` stays low and `rise_pulse` stays 0.
- R8: While the block is running, a register write takes effect at the next toggle event, and the accumulator restarts from zero at that point. A write that lands on the same edge as a toggle is adopted at the toggle after that one. While the block is stopped, a nonzero factor becomes active one cycle after the write, and the first toggle comes N cycles later for a factor of N·2^14.
- R9: `rise_pulse` is 1 exactly in the first cycle in which `clk_out` is 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the whole control register |
| fac_we | input | 1 | Write strobe for the factor field, bits 16..0 only |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control register readback |
| clk_out | output | 1 | Synthesized clock |
| rise_pulse | output | 1 | One-cycle strobe on each rising edge of `clk_out` |

## Verification
A factor write can fall on the same input edge as a toggle event. At that edge the register takes the new value while the toggle logic loads the old one. The bench provokes this with a running factor of 3.0: it locks onto an output transition, then places a `fac_we` write of 5.0 exactly three cycles later, on the toggle edge. It then requires the next half-period to last 3 cycles and the one after it to last 5.

// File: rtl/frac_clk_synth.sv
module frac_clk_synth #(
  parameter int REG_W    = 32,
  parameter int FACTOR_W = 17,
  parameter int FRAC_W   = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             fac_we,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out,
  output logic             rise_pulse
);
  localparam int ACC_W = FACTOR_W + 1;
  localparam logic [FACTOR_W-1:0] ONE_F = FACTOR_W'(1) << FRAC_W;
  localparam logic [ACC_W-1:0]    ONE_A = ACC_W'(1) << FRAC_W;

  logic [REG_W-1:0]    ctl_q;
  logic [FACTOR_W-1:0] act_q;
  logic [ACC_W-1:0]    acc_q;
  logic                out_q, rise_q;

  wire [FACTOR_W-1:0] fac_q   = ctl_q[FACTOR_W-1:0];
  wire [ACC_W-1:0]    sum     = acc_q + ONE_A;
  wire                running = act_q != '0;
  wire                sub_one = act_q < ONE_F;
  wire                toggle  = running && (sub_one || sum >= {1'b0, act_q});
  wire                restart = sub_one || fac_q != act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      act_q  <= '0;
      acc_q  <= '0;
      out_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      if (ctl_we)      ctl_q <= wr_data;
      else if (fac_we) ctl_q[FACTOR_W-1:0] <= wr_data[FACTOR_W-1:0];
      rise_q <= 1'b0;
      if (!running) begin
        act_q <= fac_q;
        acc_q <= '0;
        out_q <= 1'b0;
      end else if (toggle) begin
        act_q <= fac_q;
        acc_q <= restart ? '0 : sum - {1'b0, act_q};
        if (fac_q == '0) begin
          out_q <= 1'b0;
        end else begin
          out_q  <= ~out_q;
          rise_q <= ~out_q;
        end
      end else begin
        acc_q <= sum;
      end
    end
  end

  assign rd_data    = ctl_q;
  assign clk_out    = out_q;
  assign rise_pulse = rise_q;

  a_r1_reset_state: assert property (@(posedge clk) rst |=> (!clk_out && !rise_pulse && rd_data == '0));
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (fac_we && !ctl_we) |=> rd_data[REG_W-1:FACTOR_W] == $past(rd_data[REG_W-1:FACTOR_W]));
  a_r6_fast_toggle: assert property (@(posedge clk) disable iff (rst)
    (running && sub_one && fac_q != '0) |=> clk_out != $past(clk_out));
  a_r7_stopped_low: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!clk_out && !rise_pulse));
  a_r8_acc_bound: assert property (@(posedge clk) disable iff (rst)
    (running && !sub_one) |-> acc_q < {1'b0, act_q});
  a_r9_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> (clk_out && !$past(clk_out)));
endmodule

// File: tb/frac_clk_synth_test.sv
module frac_clk_synth_test;
  logic        clk = 1'b0, rst = 1'b1, ctl_we = 1'b0, fac_we = 1'b0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire         clk_out, rise_pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  frac_clk_synth uut (.clk(clk), .rst(rst), .ctl_we(ctl_we), .fac_we(fac_we),
    .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out), .rise_pulse(rise_pulse));

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; wr_data = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic write_fac(logic [31:0] v);
    @(negedge clk); fac_we = 1'b1; wr_data = v;
    @(negedge clk); fac_we = 1'b0;
  endtask

  task automatic wait_change(output int n);
    logic p;
    p = clk_out; n = 0;
    do begin @(negedge clk); n++; end while (clk_out == p && n < 1000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!clk_out && !rise_pulse && rd_data == 0, "R1 reset", {clk_out, rise_pulse}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!clk_out && !rise_pulse && rd_data == 0, "R1 after reset", rd_data, 0);
  endtask

  task automatic t_regs();
    write_ctl(32'hFFFE_0000);
    chk(rd_data == 32'hFFFE_0000, "R2 full write", rd_data, 32'hFFFE_0000);
    write_fac(32'h0000_C000);
    chk(rd_data == 32'hFFFE_C000, "R3 field write", rd_data, 32'hFFFE_C000);
    @(negedge clk); ctl_we = 1'b1; fac_we = 1'b1; wr_data = 32'h1234_0000;
    @(negedge clk); ctl_we = 1'b0; fac_we = 1'b0;
    chk(rd_data == 32'h1234_0000, "R3 both strobes", rd_data, 32'h1234_0000);
    write_ctl(32'h0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_integer();
    int n;
    foreach (uut.ONE_F[i]) ; // no-op keeps loop style out of the way
    for (int k = 0; k < 3; k++) begin
      int nv;
      nv = (k == 0) ? 3 : (k == 1) ? 1 : 6;
      write_fac(nv << 14);
      wait_change(n); wait_change(n);
      for (int j = 0; j < 3; j++) begin
        wait_change(n);
        chk(n == nv, "R4 integer half-period", n, nv);
      end
    end
  endtask

  task automatic t_collision();
    int n;
    write_fac(3 << 14);
    wait_change(n); wait_change(n); wait_change(n);
    @(negedge clk); @(negedge clk);
    fac_we = 1'b1; wr_data = 5 << 14;
    @(negedge clk); fac_we = 1'b0;
    wait_change(n);
    chk(n == 3, "R8 old factor kept through colliding toggle", n, 3);
    wait_change(n);
    chk(n == 5, "R8 new factor after colliding toggle", n, 5);
    write_fac(0);
    repeat (15) @(negedge clk);
    write_fac(2 << 14);
    wait_change(n);
    chk(n == 3, "R8 start from stopped", n, 3);
  endtask

  task automatic t_stop();
    int rises = 0, highs = 0;
    write_fac(3 << 14);
    repeat (20) @(negedge clk);
    write_fac(0);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rises += rise_pulse; highs += clk_out;
    end
    chk(rises == 0, "R7 no pulses when stopped", rises, 0);
    chk(highs == 0, "R7 output low when stopped", highs, 0);
  endtask

  task automatic t_sub1();
    int bad = 0;
    logic p;
    write_fac(32'h1000);
    repeat (10) @(negedge clk);
    p = clk_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_out == p) bad++;
      p = clk_out;
    end
    chk(bad == 0, "R6 toggle every cycle", bad, 0);
  endtask

  task automatic t_ratio(int d);
    int rises = 0, bad = 0;
    logic p;
    real expv;
    write_fac(d);
    repeat (60) @(negedge clk);
    p = clk_out;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (rise_pulse != (clk_out && !p)) bad++;
      rises += rise_pulse;
      p = clk_out;
    end
    expv = 6000.0 * 16384.0 / (2.0 * d);
    chk(rises >= expv - 1.0 && rises <= expv + 1.0, "R5 edge count", rises, longint'(expv));
    chk(bad == 0, "R9 rise pulse alignment", bad, 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_integer();
    t_collision();
    t_stop();
    t_sub1();
    t_ratio(24576);
    t_ratio(45056);
    t_ratio(20480);
    t_ratio(100001);
    t_ratio(16384);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule